// File: doc/BRIEF.md
# Segment Table Address Translator

This block turns a two-part logical address into a physical address using a segment table that lives in ordinary memory. A request gives a segment number, an offset within that segment and the kind of access being made: read, write or instruction fetch. The block first compares the segment number against a table length register. If the number is in range, it reads the segment's two-word entry from memory. The first word holds the segment's physical start address. The second word holds the segment length, a valid flag and three access-right flags.

The response reports one of two outcomes. One is the physical address, formed as the start address plus the offset. The other is a trap with a cause code naming the first check that failed. A table base register and a table length register are driven from outside, and the entry words come back through a read port with a one-cycle read latency, as a block RAM gives. The block handles one request at a time and signals through `req_ready` when it can take a new one.

Top module: `seg_xlate`

## Requirements
- R1: A segment number greater than or equal to `tbl_len` traps with cause 1 in the cycle after the request is accepted, and no memory read is issued for it. A segment number of `tbl_len`-1 proceeds to the fetch, and a `tbl_len` of 0 rejects every segment.
- R2: An in-range request reads the entry's two words, at word addresses `tbl_base`+2*seg and `tbl_base`+2*seg+1, on two consecutive cycles. Read data is expected one cycle after each read strobe.
- R3: If bit 16 (valid) of the entry's second word is 0, the request traps with cause 2.
- R4: Access codes are 0 for read, 1 for write and 2 for execute. These are permitted by bits 17, 18 and 19 of the second word respectively. Code 3 is never permitted. An access that is not permitted traps with cause 3.
- R5: The limit is bits 15:0 of the second word. An offset equal to or above the limit traps with cause 4, and an offset of limit-1 is accepted.
- R6: When several checks fail, the reported cause is the lowest-numbered one, in the order segment range, valid, rights, limit.
- R7: A request that passes every check responds with no trap, cause 0, and a physical address equal to bits 23:0 of the first word plus the offset, modulo 2^24. A trapped response carries address 0.
- R8: For an in-range request, `resp_valid` pulses for one cycle, four cycles after the cycle in which the request was accepted.
- R9: `req_ready` is low from acceptance until the response cycle. In the response cycle it is high, and a request presented then is accepted.
- R10: After reset, `req_ready` is 1 and `resp_valid` and `mem_rd_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_seg | input | 4 | Segment number |
| req_off | input | 16 | Offset inside the segment |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| tbl_base | input | 24 | Word address of the segment table |
| tbl_len | input | 5 | Number of segments in the table |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | 24 | Memory word address |
| mem_rd_data | input | 32 | Read data, valid one cycle after the strobe |
| resp_valid | output | 1 | Response present for one cycle |
| resp_trap | output | 1 | Response is a trap |
| resp_cause | output | 3 | Trap cause: 0 none, 1 segment range, 2 invalid, 3 rights, 4 limit |
| resp_paddr | output | 24 | Translated physical address |

## Verification
A response and the acceptance of the next request can fall in the same cycle, because the block is ready again in the cycle its result appears. The bench sends an out-of-range request, which gets its one-cycle trap response, and presents a new in-range request in exactly the cycle that the trap response shows. It then checks that the trap was reported correctly, that the second request was accepted in that cycle, and that the second request's translation arrives four cycles later with the right address. Check priority is tested with entries that fail several checks at once.

// File: rtl/seg_pkg.sv
package seg_pkg;
  typedef enum logic [1:0] {
    ACC_RD  = 2'd0,
    ACC_WR  = 2'd1,
    ACC_EX  = 2'd2,
    ACC_RSV = 2'd3
  } acc_t;

  typedef enum logic [2:0] {
    C_NONE = 3'd0,
    C_SEG  = 3'd1,
    C_INV  = 3'd2,
    C_PROT = 3'd3,
    C_LIM  = 3'd4
  } cause_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD0  = 2'd1,
    ST_RD1  = 2'd2,
    ST_FIN  = 2'd3
  } st_t;
endpackage

// File: rtl/seg_check.sv
module seg_check
  import seg_pkg::*;
#(
  parameter int OFF_W = 16,
  parameter int DW    = 32
) (
  input  logic [OFF_W-1:0] off,
  input  logic [1:0]       acc,
  input  logic [DW-1:0]    word,
  output logic             fault,
  output cause_t           cause
);
  localparam int V_B = OFF_W;
  localparam int R_B = OFF_W + 1;
  localparam int W_B = OFF_W + 2;
  localparam int X_B = OFF_W + 3;
  localparam int USED = OFF_W + 4;

  logic [OFF_W-1:0] limit;
  logic [3:0]       rights;
  logic             allowed;
  logic             unused_rsv;

  assign limit   = word[OFF_W-1:0];
  assign rights  = {1'b0, word[X_B], word[W_B], word[R_B]};
  assign allowed = rights[acc];

  generate
    if (DW > USED) begin : g_rsv
      assign unused_rsv = ^word[DW-1:USED];
    end else begin : g_norsv
      assign unused_rsv = 1'b0;
    end
  endgenerate

  // valid, then rights, then limit (R6)
  always_comb begin
    fault = 1'b1;
    if (!word[V_B])          cause = C_INV;
    else if (!allowed)       cause = C_PROT;
    else if (off >= limit)   cause = C_LIM;
    else begin
      cause = C_NONE;
      fault = 1'b0;
    end
  end
endmodule

// File: rtl/seg_ctrl.sv
module seg_ctrl
  import seg_pkg::*;
#(
  parameter int SEG_W = 4,
  parameter int OFF_W = 16,
  parameter int PA_W  = 24,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [SEG_W-1:0] req_seg,
  input  logic [OFF_W-1:0] req_off,
  input  logic [1:0]       req_acc,
  input  logic [PA_W-1:0]  tbl_base,
  input  logic [SEG_W:0]   tbl_len,
  output logic             mem_rd_en,
  output logic [PA_W-1:0]  mem_rd_addr,
  input  logic [DW-1:0]    mem_rd_data,
  output logic [OFF_W-1:0] lat_off,
  output logic [1:0]       lat_acc,
  input  logic             chk_fault,
  input  cause_t           chk_cause,
  output logic             resp_valid,
  output logic             resp_trap,
  output logic [2:0]       resp_cause,
  output logic [PA_W-1:0]  resp_paddr
);
  st_t             state;
  logic [PA_W-1:0] seg_base;
  logic            seg_bad;
  logic            unused_hi;

  assign req_ready = (state == ST_IDLE);
  assign seg_bad   = ({1'b0, req_seg} >= tbl_len);
  assign unused_hi = ^mem_rd_data[DW-1:PA_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      mem_rd_en   <= 1'b0;
      mem_rd_addr <= '0;
      seg_base    <= '0;
      lat_off     <= '0;
      lat_acc     <= '0;
      resp_valid  <= 1'b0;
      resp_trap   <= 1'b0;
      resp_cause  <= C_NONE;
      resp_paddr  <= '0;
    end else begin
      resp_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            lat_off <= req_off;
            lat_acc <= req_acc;
            if (seg_bad) begin
              resp_valid <= 1'b1;
              resp_trap  <= 1'b1;
              resp_cause <= C_SEG;
              resp_paddr <= '0;
            end else begin
              mem_rd_en   <= 1'b1;
              mem_rd_addr <= tbl_base + PA_W'({req_seg, 1'b0});
              state       <= ST_RD0;
            end
          end
        end
        ST_RD0: begin
          mem_rd_addr <= mem_rd_addr + PA_W'(1);
          state       <= ST_RD1;
        end
        ST_RD1: begin
          mem_rd_en <= 1'b0;
          seg_base  <= mem_rd_data[PA_W-1:0];
          state     <= ST_FIN;
        end
        default: begin
          resp_valid <= 1'b1;
          resp_trap  <= chk_fault;
          resp_cause <= chk_cause;
          resp_paddr <= chk_fault ? '0 : seg_base + PA_W'(lat_off);
          state      <= ST_IDLE;
        end
      endcase
    end
  end

  a_r1_no_fetch: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && ({1'b0, req_seg} >= tbl_len)) |=>
      (!mem_rd_en && resp_valid && resp_trap && resp_cause == C_SEG));

  a_r2_second_word: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_rd_en) |=> (mem_rd_en && mem_rd_addr == $past(mem_rd_addr) + PA_W'(1)));

  a_r8_resp_after_fetch: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_rd_en) |=> resp_valid);

  a_r9_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |-> !req_ready);

  a_r7_ok_no_cause: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && !resp_trap) |-> (resp_cause == C_NONE));

  a_r6_trap_has_cause: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && resp_trap) |-> (resp_cause != C_NONE && resp_cause <= C_LIM));
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_pkg::*;
#(
  parameter int SEG_W = 4,
  parameter int OFF_W = 16,
  parameter int PA_W  = 24,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [SEG_W-1:0] req_seg,
  input  logic [OFF_W-1:0] req_off,
  input  logic [1:0]       req_acc,
  input  logic [PA_W-1:0]  tbl_base,
  input  logic [SEG_W:0]   tbl_len,
  output logic             mem_rd_en,
  output logic [PA_W-1:0]  mem_rd_addr,
  input  logic [DW-1:0]    mem_rd_data,
  output logic             resp_valid,
  output logic             resp_trap,
  output logic [2:0]       resp_cause,
  output logic [PA_W-1:0]  resp_paddr
);
  logic [OFF_W-1:0] lat_off;
  logic [1:0]       lat_acc;
  logic             chk_fault;
  cause_t           chk_cause;

  seg_check #(.OFF_W(OFF_W), .DW(DW)) u_chk (
    .off   (lat_off),
    .acc   (lat_acc),
    .word  (mem_rd_data),
    .fault (chk_fault),
    .cause (chk_cause)
  );

  seg_ctrl #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W), .DW(DW)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_seg     (req_seg),
    .req_off     (req_off),
    .req_acc     (req_acc),
    .tbl_base    (tbl_base),
    .tbl_len     (tbl_len),
    .mem_rd_en   (mem_rd_en),
    .mem_rd_addr (mem_rd_addr),
    .mem_rd_data (mem_rd_data),
    .lat_off     (lat_off),
    .lat_acc     (lat_acc),
    .chk_fault   (chk_fault),
    .chk_cause   (chk_cause),
    .resp_valid  (resp_valid),
    .resp_trap   (resp_trap),
    .resp_cause  (resp_cause),
    .resp_paddr  (resp_paddr)
  );
endmodule

// File: tb/sim_seg_xlate.sv
module sim_seg_xlate;
  localparam int CLK_P = 10;
  localparam logic [23:0] TB = 24'h000020;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [3:0]  req_seg = '0;
  logic [15:0] req_off = '0;
  logic [1:0]  req_acc = '0;
  logic [23:0] tbl_base = TB;
  logic [4:0]  tbl_len = 5'd5;
  logic        mem_rd_en;
  logic [23:0] mem_rd_addr;
  logic [31:0] mem_rd_data = '0;
  logic        resp_valid;
  logic        resp_trap;
  logic [2:0]  resp_cause;
  logic [23:0] resp_paddr;

  logic [31:0] mem [0:255];
  int          rd_cnt;
  logic [23:0] rd_a0, rd_a1;
  int          n_chk = 0;
  int          n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  seg_xlate u0 (.*);

  always @(posedge clk) begin
    if (mem_rd_en) begin
      mem_rd_data <= mem[mem_rd_addr[7:0]];
      if (rd_cnt == 0) rd_a0 = mem_rd_addr;
      if (rd_cnt == 1) rd_a1 = mem_rd_addr;
      rd_cnt = rd_cnt + 1;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // second word layout: [19] X, [18] W, [17] R, [16] valid, [15:0] limit
  task automatic put(input int s, input logic [23:0] base, input logic [15:0] lim,
                     input logic v, input logic r, input logic w, input logic x);
    mem[TB[7:0] + 2*s]     = {8'h00, base};
    mem[TB[7:0] + 2*s + 1] = {12'h000, x, w, r, v, lim};
  endtask

  // issue one request, return response, latency in cycles and read count
  task automatic xl(input logic [3:0] s, input logic [15:0] o, input logic [1:0] a,
                    output logic trap, output logic [2:0] c, output logic [23:0] pa,
                    output int lat, output logic busy);
    @(negedge clk);
    rd_cnt = 0;
    req_valid = 1'b1; req_seg = s; req_off = o; req_acc = a;
    lat = 0;
    busy = 1'b0;
    do begin
      @(negedge clk);
      lat++;
      if (lat == 1) begin
        req_valid = 1'b0;
        busy = !req_ready;
      end
    end while (!resp_valid && lat < 20);
    trap = resp_trap; c = resp_cause; pa = resp_paddr;
  endtask

  task automatic t_ok(input string req, input logic [3:0] s, input logic [15:0] o,
                      input logic [1:0] a, input logic [23:0] exp_pa);
    logic t; logic [2:0] c; logic [23:0] pa; int lat; logic b;
    xl(s, o, a, t, c, pa, lat, b);
    chk(req, "trap", {31'd0, t}, 32'd0);
    chk(req, "cause", {29'd0, c}, 32'd0);
    chk(req, "paddr", {8'd0, pa}, {8'd0, exp_pa});
    chk("R8", "latency", lat, 4);
  endtask

  task automatic t_trap(input string req, input logic [3:0] s, input logic [15:0] o,
                        input logic [1:0] a, input logic [2:0] exp_c);
    logic t; logic [2:0] c; logic [23:0] pa; int lat; logic b;
    xl(s, o, a, t, c, pa, lat, b);
    chk(req, "trap", {31'd0, t}, 32'd1);
    chk(req, "cause", {29'd0, c}, {29'd0, exp_c});
    chk("R7", "trap paddr", {8'd0, pa}, 32'd0);
    chk(req, "latency", lat, (exp_c == 3'd1) ? 1 : 4);
    chk(req, "reads", rd_cnt, (exp_c == 3'd1) ? 0 : 2);
  endtask

  task automatic t_reset();
    chk("R10", "req_ready", {31'd0, req_ready}, 32'd1);
    chk("R10", "resp_valid", {31'd0, resp_valid}, 32'd0);
    chk("R10", "mem_rd_en", {31'd0, mem_rd_en}, 32'd0);
  endtask

  task automatic t_fetch_addr();
    logic t; logic [2:0] c; logic [23:0] pa; int lat; logic b;
    xl(4'd1, 16'h0010, 2'd0, t, c, pa, lat, b);
    chk("R2", "read count", rd_cnt, 2);
    chk("R2", "first addr", {8'd0, rd_a0}, {8'd0, TB + 24'd2});
    chk("R2", "second addr", {8'd0, rd_a1}, {8'd0, TB + 24'd3});
    chk("R9", "busy after accept", {31'd0, b}, 32'd1);
    chk("R7", "paddr", {8'd0, pa}, 32'h200010);
  endtask

  task automatic t_seg_range();
    t_trap("R1", 4'd5, 16'h0000, 2'd0, 3'd1);
    t_trap("R1", 4'd15, 16'h0001, 2'd0, 3'd1);
    t_ok("R1", 4'd4, 16'h0003, 2'd0, 24'h300003);
    tbl_len = 5'd0;
    t_trap("R1", 4'd0, 16'h0000, 2'd0, 3'd1);
    tbl_len = 5'd5;
  endtask

  task automatic t_b2b();
    int lat;
    @(negedge clk);
    rd_cnt = 0;
    req_valid = 1'b1; req_seg = 4'd9; req_off = 16'h0; req_acc = 2'd0;
    @(negedge clk);
    chk("R9", "trap shown", {31'd0, resp_valid && resp_trap}, 32'd1);
    chk("R1", "trap cause", {29'd0, resp_cause}, 32'd1);
    chk("R9", "ready in resp cycle", {31'd0, req_ready}, 32'd1);
    req_seg = 4'd0; req_off = 16'h0ABC; req_acc = 2'd2;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
      if (lat == 1) req_valid = 1'b0;
    end while (!resp_valid && lat < 20);
    chk("R9", "second accepted latency", lat, 4);
    chk("R9", "second paddr", {8'd0, resp_paddr}, 32'h100ABC);
    chk("R9", "second trap", {31'd0, resp_trap}, 32'd0);
    @(negedge clk);
    chk("R8", "one-cycle pulse", {31'd0, resp_valid}, 32'd0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    put(0, 24'h100000, 16'h1000, 1'b1, 1'b1, 1'b0, 1'b1);
    put(1, 24'h200000, 16'h0800, 1'b1, 1'b1, 1'b1, 1'b0);
    put(2, 24'h000000, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0);
    put(3, 24'hFFFFF0, 16'h0100, 1'b1, 1'b1, 1'b0, 1'b0);
    put(4, 24'h300000, 16'h0010, 1'b1, 1'b1, 1'b0, 1'b0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_ok("R7", 4'd0, 16'h0123, 2'd0, 24'h100123);
    t_ok("R4", 4'd0, 16'h0040, 2'd2, 24'h100040);
    t_ok("R5", 4'd1, 16'h07FF, 2'd1, 24'h2007FF);
    t_fetch_addr();
    t_trap("R4", 4'd0, 16'h0001, 2'd1, 3'd3);
    t_trap("R4", 4'd1, 16'h0001, 2'd3, 3'd3);
    t_trap("R4", 4'd1, 16'h0001, 2'd2, 3'd3);
    t_trap("R5", 4'd1, 16'h0800, 2'd0, 3'd4);
    t_trap("R3", 4'd2, 16'h0000, 2'd0, 3'd2);
    t_trap("R6", 4'd2, 16'hFFFF, 2'd1, 3'd2);
    t_trap("R6", 4'd4, 16'h0020, 2'd1, 3'd3);
    t_ok("R7", 4'd3, 16'h0020, 2'd0, 24'h000010);
    t_seg_range();
    t_b2b();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_P * 50000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule